// File: doc/BRIEF.md
# Processor Mode and Mask Status Word

This block keeps a 16-bit processor status word that collects interrupt and debug masks, addressing and compatibility modes, hardware-owned status flags, an external flag and a 3-bit auxiliary register pointer. It comes out of reset with both masks disabled, the memory-block map mode set, the vector-map bit copied from an input pin, and every other bit cleared.

During operation the instruction decoder sets or clears single bits through a command port. The interrupt-return and register-load paths restore the whole word in one cycle. A separate port loads the pointer field. Two hardware status inputs drive the loop-active and idle flags. Whenever the object-mode bit or the memory-block map bit is commanded, the block raises a one-cycle request to flush the pipeline. The status word, the individual mode signals and an external flag pin are driven straight from the register.

Top module: `cpu_mode_status`

## Requirements
- R1: While `rst_n` is low, `status_word` equals 0x0803 with bit 3 equal to `vec_map_in`. That is, bits 0, 1 and 11 are 1, bit 3 follows the pin and all other bits are 0.
- R2: When `cmd_valid` is high with `cmd_bit` in {0,1,2,3,4,6,8,9,11,12}, the selected bit takes the value of `cmd_set` (1 = set, 0 = clear) at the next rising clock edge.
- R3: A command with `cmd_bit` of 5, 7, 10, 13, 14 or 15 leaves all register bits unchanged. Bits 5 and 7 still follow R8.
- R4: When `restore_valid` is high, bits 0–4, 6, 8, 9 and 12–15 load from `restore_word` at the next edge. Bits 5, 7, 10 and 11 ignore the restore word.
- R5: Bit 11 (memory-block map) changes only through a command with `cmd_bit` = 11. A restore never alters it.
- R6: When a command and a restore arrive in the same cycle, the commanded bit takes the command value. The other restorable bits take the restore word.
- R7: When `arp_wr_valid` is high, bits 15:13 load from `arp_wr_data` at the next edge. This takes priority over a restore in the same cycle.
- R8: Bit 5 equals `loop_busy_in` and bit 7 equals `idle_busy_in`, each as sampled at the previous rising edge.
- R9: `flush_req` is high for exactly the cycle after each cycle in which `cmd_valid` is high with `cmd_bit` of 9 or 11. This holds whether the bit changes or not. Otherwise `flush_req` is low.
- R10: `int_masked`, `dbg_masked`, `addr_mode`, `obj_mode`, `blk_map_mode` and `flag_pin` always equal status bits 0, 1, 8, 9, 11 and 12.
- R11: Bit 10 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_map_in | input | 1 | Reset value of the vector-map bit (bit 3) |
| cmd_valid | input | 1 | Single-bit set/clear command strobe |
| cmd_bit | input | 4 | Bit index the command targets |
| cmd_set | input | 1 | 1 = set the bit, 0 = clear it |
| restore_valid | input | 1 | Whole-word restore strobe |
| restore_word | input | 16 | Word to restore |
| arp_wr_valid | input | 1 | Pointer field write strobe |
| arp_wr_data | input | 3 | New pointer value |
| loop_busy_in | input | 1 | Hardware loop-active status |
| idle_busy_in | input | 1 | Hardware idle status |
| status_word | output | 16 | Current status register |
| int_masked | output | 1 | Interrupt mask bit |
| dbg_masked | output | 1 | Debug mask bit |
| addr_mode | output | 1 | Address mode bit |
| obj_mode | output | 1 | Object mode bit |
| blk_map_mode | output | 1 | Memory-block map mode bit |
| flag_pin | output | 1 | External flag output |
| flush_req | output | 1 | One-cycle pipeline-flush request |

## Verification
The assertions take all inputs to be synchronous to `clk` and free of X once reset is released. They make no assumption about which strobes coincide, because any mix of command, restore and pointer write is legal. They rely on `cmd_bit` being sampled only while `cmd_valid` is high. The stimulus draws every strobe and field from a fixed-seed generator and changes inputs only on the falling edge. It also applies directed cycles that stack all three write sources on one edge, repeat a flush-bit command on a bit that already holds the value, and reset twice with opposite `vec_map_in` levels.

// File: rtl/st1_pkg.sv
package st1_pkg;
  localparam int ST_W    = 16;
  localparam int IDX_W   = $clog2(ST_W);
  localparam int ARP_W   = 3;
  localparam int ARP_LSB = ST_W - ARP_W;

  localparam int B_IMASK = 0;
  localparam int B_DMASK = 1;
  localparam int B_PG0   = 2;
  localparam int B_VMAP  = 3;
  localparam int B_SALN  = 4;
  localparam int B_LOOP  = 5;
  localparam int B_PROT  = 6;
  localparam int B_IDLE  = 7;
  localparam int B_AMODE = 8;
  localparam int B_OBJ   = 9;
  localparam int B_RSVD  = 10;
  localparam int B_MAP   = 11;
  localparam int B_FLAG  = 12;

  localparam logic [ST_W-1:0] ONE = {{(ST_W-1){1'b0}}, 1'b1};

  localparam logic [ST_W-1:0] ARP_MASK = {ARP_W{1'b1}} << ARP_LSB;

  localparam logic [ST_W-1:0] RESTORE_MASK =
      (ONE << B_IMASK) | (ONE << B_DMASK) | (ONE << B_PG0) |
      (ONE << B_VMAP)  | (ONE << B_SALN)  | (ONE << B_PROT) |
      (ONE << B_AMODE) | (ONE << B_OBJ)   | (ONE << B_FLAG) | ARP_MASK;

  localparam logic [ST_W-1:0] CMD_MASK =
      (RESTORE_MASK & ~ARP_MASK) | (ONE << B_MAP);

  function automatic logic cmd_target_ok(input logic [IDX_W-1:0] idx);
    return CMD_MASK[idx];
  endfunction

  function automatic logic is_flush_bit(input logic [IDX_W-1:0] idx);
    return (int'(idx) == B_OBJ) || (int'(idx) == B_MAP);
  endfunction

  function automatic logic [ST_W-1:0] merge_restore(input logic [ST_W-1:0] cur,
                                                    input logic [ST_W-1:0] word);
    return (cur & ~RESTORE_MASK) | (word & RESTORE_MASK);
  endfunction

  function automatic logic [ST_W-1:0] put_arp(input logic [ST_W-1:0] word,
                                              input logic [ARP_W-1:0] arp);
    logic [ST_W-1:0] w;
    w = word;
    w[ARP_LSB +: ARP_W] = arp;
    return w;
  endfunction

  function automatic logic [ST_W-1:0] put_bit(input logic [ST_W-1:0] word,
                                              input logic [IDX_W-1:0] idx,
                                              input logic val);
    logic [ST_W-1:0] w;
    w = word;
    w[idx] = val;
    return w;
  endfunction

  function automatic logic [ST_W-1:0] reset_word(input logic vmap);
    return (ONE << B_IMASK) | (ONE << B_DMASK) | (ONE << B_MAP) |
           ({{(ST_W-1){1'b0}}, vmap} << B_VMAP);
  endfunction
endpackage

// File: rtl/st1_next.sv
module st1_next
  import st1_pkg::*;
(
  input  logic [ST_W-1:0]  cur,
  input  logic             restore_v,
  input  logic [ST_W-1:0]  restore_w,
  input  logic             arp_v,
  input  logic [ARP_W-1:0] arp_d,
  input  logic             cmd_v,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic             cmd_val,
  input  logic             loop_in,
  input  logic             idle_in,
  output logic [ST_W-1:0]  nxt,
  output logic             cmd_taken,
  output logic             flush_evt
);
  logic [ST_W-1:0] t;

  always_comb begin
    t = cur;
    t[B_LOOP] = loop_in;
    t[B_IDLE] = idle_in;
    if (restore_v) t = merge_restore(t, restore_w);
    if (arp_v)     t = put_arp(t, arp_d);
    cmd_taken = cmd_v && cmd_target_ok(cmd_idx);
    if (cmd_taken) t = put_bit(t, cmd_idx, cmd_val);
    t[B_RSVD] = 1'b0;
    nxt = t;
    flush_evt = cmd_v && is_flush_bit(cmd_idx);
  end
endmodule

// File: rtl/st1_state.sv
module st1_state
  import st1_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vmap_pin,
  input  logic [ST_W-1:0] nxt,
  input  logic            map_cmd,
  output logic [ST_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= reset_word(vmap_pin);
    else        q <= nxt;
  end

  // R5: the map bit moves only when its own command was seen
  p_map_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !map_cmd |=> $stable(q[B_MAP]));

  // R11: reserved bit never reads 1
  p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    q[B_RSVD] == 1'b0);
endmodule

// File: rtl/st1_flush.sv
module st1_flush (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= trig;
  end
endmodule

// File: rtl/cpu_mode_status.sv
module cpu_mode_status
  import st1_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vec_map_in,
  input  logic             cmd_valid,
  input  logic [IDX_W-1:0] cmd_bit,
  input  logic             cmd_set,
  input  logic             restore_valid,
  input  logic [ST_W-1:0]  restore_word,
  input  logic             arp_wr_valid,
  input  logic [ARP_W-1:0] arp_wr_data,
  input  logic             loop_busy_in,
  input  logic             idle_busy_in,
  output logic [ST_W-1:0]  status_word,
  output logic             int_masked,
  output logic             dbg_masked,
  output logic             addr_mode,
  output logic             obj_mode,
  output logic             blk_map_mode,
  output logic             flag_pin,
  output logic             flush_req
);
  logic [ST_W-1:0] st_q;
  logic [ST_W-1:0] st_nxt;
  logic            cmd_taken;
  logic            flush_evt;
  logic            map_cmd;

  assign map_cmd = cmd_valid && (int'(cmd_bit) == B_MAP);

  st1_next u_next (
    .cur       (st_q),
    .restore_v (restore_valid),
    .restore_w (restore_word),
    .arp_v     (arp_wr_valid),
    .arp_d     (arp_wr_data),
    .cmd_v     (cmd_valid),
    .cmd_idx   (cmd_bit),
    .cmd_val   (cmd_set),
    .loop_in   (loop_busy_in),
    .idle_in   (idle_busy_in),
    .nxt       (st_nxt),
    .cmd_taken (cmd_taken),
    .flush_evt (flush_evt)
  );

  st1_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .vmap_pin (vec_map_in),
    .nxt      (st_nxt),
    .map_cmd  (map_cmd),
    .q        (st_q)
  );

  st1_flush u_flush (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (flush_evt),
    .req   (flush_req)
  );

  assign status_word  = st_q;
  assign int_masked   = st_q[B_IMASK];
  assign dbg_masked   = st_q[B_DMASK];
  assign addr_mode    = st_q[B_AMODE];
  assign obj_mode     = st_q[B_OBJ];
  assign blk_map_mode = st_q[B_MAP];
  assign flag_pin     = st_q[B_FLAG];

  // R9: commanded flush bit gives a request next cycle
  p_flush_on_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (int'(cmd_bit) == B_OBJ || int'(cmd_bit) == B_MAP)) |=> flush_req);

  // R9: no request without such a command
  p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && (int'(cmd_bit) == B_OBJ || int'(cmd_bit) == B_MAP)) |=> !flush_req);

  // R6 / R2: an accepted command sets its bit whatever else arrives
  p_cmd_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_taken |=> status_word[$past(cmd_bit)] == $past(cmd_set));

  // R8: hardware flags track their inputs with one register delay
  p_hw_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_word[B_LOOP] == $past(loop_busy_in)) &&
             (status_word[B_IDLE] == $past(idle_busy_in)));

  // R7: pointer write port lands in the top field
  p_arp_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arp_wr_valid |=> status_word[ARP_LSB +: ARP_W] == $past(arp_wr_data));
endmodule

// File: tb/cpu_mode_status_test.sv
`timescale 1ns/1ps
module cpu_mode_status_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vec_map_in = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_bit = 4'd0;
  logic        cmd_set = 1'b0;
  logic        restore_valid = 1'b0;
  logic [15:0] restore_word = 16'h0;
  logic        arp_wr_valid = 1'b0;
  logic [2:0]  arp_wr_data = 3'd0;
  logic        loop_busy_in = 1'b0;
  logic        idle_busy_in = 1'b0;
  logic [15:0] status_word;
  logic        int_masked, dbg_masked, addr_mode, obj_mode, blk_map_mode, flag_pin;
  logic        flush_req;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_w;
  logic        exp_f;

  always #2 clk = ~clk;

  cpu_mode_status uut (
    .clk(clk), .rst_n(rst_n), .vec_map_in(vec_map_in),
    .cmd_valid(cmd_valid), .cmd_bit(cmd_bit), .cmd_set(cmd_set),
    .restore_valid(restore_valid), .restore_word(restore_word),
    .arp_wr_valid(arp_wr_valid), .arp_wr_data(arp_wr_data),
    .loop_busy_in(loop_busy_in), .idle_busy_in(idle_busy_in),
    .status_word(status_word), .int_masked(int_masked), .dbg_masked(dbg_masked),
    .addr_mode(addr_mode), .obj_mode(obj_mode), .blk_map_mode(blk_map_mode),
    .flag_pin(flag_pin), .flush_req(flush_req)
  );

  // Per-bit model built from the requirement text
  function automatic logic [15:0] model(input logic [15:0] w, input logic cv,
      input logic [3:0] ci, input logic cs, input logic rv, input logic [15:0] rw,
      input logic av, input logic [2:0] ad, input logic lp, input logic id);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) begin
      case (i)
        5:  r[i] = lp;                                   // R8
        7:  r[i] = id;                                   // R8
        10: r[i] = 1'b0;                                 // R11
        11: r[i] = (cv && ci == 4'd11) ? cs : w[i];      // R5
        13, 14, 15: r[i] = av ? ad[i-13] : (rv ? rw[i] : w[i]); // R7
        default: r[i] = (cv && ci == 4'(i)) ? cs : (rv ? rw[i] : w[i]); // R2 R4 R6
      endcase
    end
    return r;
  endfunction

  function automatic logic [15:0] rst_val(input logic v);
    return 16'h0803 | (v ? 16'h0008 : 16'h0000);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_pins(input logic [15:0] e);
    check("R10", {10'd0, int_masked, dbg_masked, addr_mode, obj_mode, blk_map_mode, flag_pin},
          {10'd0, e[0], e[1], e[8], e[9], e[11], e[12]});
  endtask

  task automatic step(input logic cv, input logic [3:0] ci, input logic cs,
      input logic rv, input logic [15:0] rw, input logic av, input logic [2:0] ad,
      input logic lp, input logic id, input string tag);
    logic [15:0] nw;
    cmd_valid = cv; cmd_bit = ci; cmd_set = cs;
    restore_valid = rv; restore_word = rw;
    arp_wr_valid = av; arp_wr_data = ad;
    loop_busy_in = lp; idle_busy_in = id;
    nw = model(exp_w, cv, ci, cs, rv, rw, av, ad, lp, id);
    exp_f = cv && (ci == 4'd9 || ci == 4'd11);
    @(negedge clk);
    exp_w = nw;
    check(tag, status_word, exp_w);
    check("R9", {15'd0, flush_req}, {15'd0, exp_f});
    check_pins(exp_w);
  endtask

  task automatic idle_step(input string tag);
    step(1'b0, 4'd0, 1'b0, 1'b0, 16'h0, 1'b0, 3'd0, 1'b0, 1'b0, tag);
  endtask

  task automatic do_reset(input logic v);
    @(negedge clk);
    rst_n = 1'b0; vec_map_in = v;
    cmd_valid = 1'b0; restore_valid = 1'b0; arp_wr_valid = 1'b0;
    loop_busy_in = 1'b0; idle_busy_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", status_word, rst_val(v));
    check("R1", {15'd0, flush_req}, 16'h0);
    rst_n = 1'b1;
    exp_w = rst_val(v);
  endtask

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    string tag;
    logic cv, cs, rv, av, lp, id;
    logic [3:0] ci;
    logic [15:0] rw;
    logic [2:0] ad;
    seed = 12345;
    void'($urandom(seed));

    do_reset(1'b1);
    idle_step("R1");
    // R2: set object mode, then flush again when re-set (R9)
    step(1'b1, 4'd9, 1'b1, 1'b0, 16'h0, 1'b0, 3'd0, 1'b0, 1'b0, "R2");
    step(1'b1, 4'd9, 1'b1, 1'b0, 16'h0, 1'b0, 3'd0, 1'b0, 1'b0, "R9");
    idle_step("R9");
    // R3: commands on read-only / pointer indices are ignored
    step(1'b1, 4'd5, 1'b1, 1'b0, 16'h0, 1'b0, 3'd0, 1'b0, 1'b0, "R3");
    step(1'b1, 4'd10, 1'b1, 1'b0, 16'h0, 1'b0, 3'd0, 1'b0, 1'b0, "R3");
    step(1'b1, 4'd14, 1'b1, 1'b0, 16'h0, 1'b0, 3'd0, 1'b0, 1'b0, "R3");
    // R4 / R5 / R11: restore of all ones leaves bits 10 and 11 alone
    step(1'b1, 4'd11, 1'b0, 1'b0, 16'h0, 1'b0, 3'd0, 1'b0, 1'b0, "R5");
    step(1'b0, 4'd0, 1'b0, 1'b1, 16'hFFFF, 1'b0, 3'd0, 1'b0, 1'b0, "R4");
    check("R5", {15'd0, blk_map_mode}, 16'h0);
    check("R11", {15'd0, status_word[10]}, 16'h0);
    step(1'b0, 4'd0, 1'b0, 1'b1, 16'h0800, 1'b0, 3'd0, 1'b0, 1'b0, "R5");
    // R6: command beats restore; R7: pointer port beats restore
    step(1'b1, 4'd12, 1'b0, 1'b1, 16'hFFFF, 1'b1, 3'd2, 1'b0, 1'b0, "R6");
    check("R6", {15'd0, flag_pin}, 16'h0);
    check("R7", {13'd0, status_word[15:13]}, 16'h0002);
    // R8: hardware flags
    step(1'b0, 4'd0, 1'b0, 1'b0, 16'h0, 1'b0, 3'd0, 1'b1, 1'b1, "R8");
    step(1'b1, 4'd7, 1'b0, 1'b0, 16'h0, 1'b0, 3'd0, 1'b1, 1'b1, "R8");

    for (int n = 0; n < 3000; n++) begin
      cv = ($urandom % 3) == 0;
      ci = 4'($urandom);
      cs = 1'($urandom);
      rv = ($urandom % 4) == 0;
      rw = 16'($urandom);
      av = ($urandom % 5) == 0;
      ad = 3'($urandom);
      lp = 1'($urandom);
      id = 1'($urandom);
      if (cv && rv) tag = "R6";
      else if (av) tag = "R7";
      else if (rv) tag = "R4";
      else if (cv && (ci == 4'd5 || ci == 4'd7 || ci == 4'd10 || ci > 4'd12)) tag = "R3";
      else if (cv) tag = "R2";
      else tag = "R8";
      step(cv, ci, cs, rv, rw, av, ad, lp, id, tag);
    end

    do_reset(1'b0);
    idle_step("R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule